// File: doc/BRIEF.md
# USART Multi-Mode Clock Generator

This block produces the bit-timing enables for a USART transmitter and receiver. It runs in one of four clock modes: asynchronous at 16 samples per bit, asynchronous at 8 samples per bit, synchronous with the block driving the serial clock pin, and synchronous with the serial clock taken from that pin. A single base tick comes from a reloading down-counter loaded with a 12-bit baud divisor. The async modes, the master clock and the slave edge detector all derive their enables from that tick or from the pin.

The receive enable `rx_en_o` and the transmit enable `tx_en_o` are one-cycle strobes in the system clock domain. In async modes `rx_en_o` is the oversampling strobe and `tx_en_o` marks each bit boundary. In sync modes `rx_en_o` marks the rising serial-clock edge and `tx_en_o` marks the falling edge. The framing, shift and parity logic that uses these strobes sits outside this block.

Top module: `uclk_gen`

## Requirements
- R1: `sync_mode_i` = 0 selects async operation and 1 selects sync operation. In sync operation, `xck_dir_i` = 1 selects master and 0 selects slave.
- R2: The base tick repeats every `baud_div_i`+1 system cycles. In async modes `rx_en_o` pulses once per base tick. The first pulse after a restart comes after `baud_div_i`+1 cycles.
- R3: In async mode with `dbl_speed_i` = 0, `tx_en_o` pulses once every 16 base ticks, on the same cycle as an `rx_en_o` pulse.
- R4: In async mode with `dbl_speed_i` = 1, `tx_en_o` pulses once every 8 base ticks.
- R5: In sync modes `dbl_speed_i` is ignored. Changing it neither restarts nor retimes the enables.
- R6: In async modes `xck_oe_o` and `xck_o` stay 0, and activity on `xck_i` has no effect on the enables.
- R7: In master mode `xck_oe_o` = 1 and `xck_o` toggles on every base tick, starting low after a restart. Its period is 2×(`baud_div_i`+1). `rx_en_o` pulses on the tick that drives the pin high and `tx_en_o` on the tick that drives it low. The two never coincide.
- R8: In slave mode `xck_oe_o` = 0 and `xck_o` = 0. A rising edge on `xck_i` gives a one-cycle `rx_en_o` pulse, and a falling edge gives a `tx_en_o` pulse. Each pulse is visible two clock edges after the pin changes.
- R9: A change of mode or divisor restarts the generator. The counter reloads, the oversampling phase clears and the master clock returns low, so the first bit after the change has full length. In async mode a changed `dbl_speed_i` is a mode change.
- R10: While `rst_ni` is low, `tx_en_o`, `rx_en_o` and `xck_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_mode_i | input | 1 | 0 = async, 1 = sync |
| dbl_speed_i | input | 1 | Async double speed (8 samples per bit) |
| xck_dir_i | input | 1 | Serial clock pin direction, 1 = output (master) |
| baud_div_i | input | 12 | Baud divisor; tick period is value+1 |
| xck_i | input | 1 | Serial clock pin input |
| tx_en_o | output | 1 | Transmit enable strobe |
| rx_en_o | output | 1 | Receive/sample enable strobe |
| xck_o | output | 1 | Serial clock pin output value |
| xck_oe_o | output | 1 | Serial clock pin output enable |

## Verification
The assertions assume that every level on `xck_i` in slave mode lasts at least two system cycles. That is the case when the external clock runs below a quarter of the system clock, and it makes the slave strobes isolated single-cycle pulses. They also assume that the configuration inputs change only between clock edges, so a restart is recognised at the next edge. The stimulus changes configuration only at falling clock edges. It drives the slave pin with six-cycle levels, and it toggles the pin every three cycles during the async pin test.

// File: rtl/uclk_pkg.sv
`timescale 1ns/1ps
package uclk_pkg;

  typedef enum logic [1:0] {
    MODE_ASYNC_X16   = 2'd0,
    MODE_ASYNC_X8    = 2'd1,
    MODE_SYNC_MASTER = 2'd2,
    MODE_SYNC_SLAVE  = 2'd3
  } clk_mode_e;

  // dbl only meaningful async, dir only meaningful sync
  function automatic clk_mode_e decode_mode(logic sync, logic dbl, logic dir);
    if (!sync) return dbl ? MODE_ASYNC_X8 : MODE_ASYNC_X16;
    return dir ? MODE_SYNC_MASTER : MODE_SYNC_SLAVE;
  endfunction

endpackage

// File: rtl/uclk_cfg_watch.sv
`timescale 1ns/1ps
module uclk_cfg_watch
  import uclk_pkg::*;
#(
  parameter int DIV_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_i,
  input  logic             dbl_i,
  input  logic             dir_i,
  input  logic [DIV_W-1:0] div_i,
  output clk_mode_e        mode_o,
  output logic             restart_o
);
  localparam int CFG_W = DIV_W + 2;

  logic [CFG_W-1:0] cfg_d, cfg_q;
  logic             armed_q;

  assign mode_o = decode_mode(sync_i, dbl_i, dir_i);
  assign cfg_d  = {mode_o, div_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      cfg_q   <= cfg_d;
      armed_q <= 1'b1;
    end
  end

  // first edge out of reset always restarts
  assign restart_o = !armed_q || (cfg_d != cfg_q);

endmodule

// File: rtl/uclk_base_cnt.sv
`timescale 1ns/1ps
module uclk_base_cnt #(
  parameter int DIV_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (restart_i || at_zero) cnt_q <= div_i;
    else                           cnt_q <= cnt_q - 1'b1;
  end

  assign tick_o = at_zero && !restart_i;

endmodule

// File: rtl/uclk_async_phase.sv
`timescale 1ns/1ps
module uclk_async_phase #(
  parameter int OVS_NORM = 16,
  parameter int OVS_DBL  = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic run_i,
  input  logic dbl_i,
  input  logic tick_i,
  output logic bit_en_o
);
  localparam int PH_W = $clog2(OVS_NORM);
  localparam logic [PH_W-1:0] LAST_NORM = PH_W'(OVS_NORM - 1);
  localparam logic [PH_W-1:0] LAST_DBL  = PH_W'(OVS_DBL - 1);

  logic [PH_W-1:0] phase_q;
  logic [PH_W-1:0] last;
  logic            wrap;

  assign last = dbl_i ? LAST_DBL : LAST_NORM;
  assign wrap = (phase_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 phase_q <= '0;
    else if (restart_i || !run_i) phase_q <= '0;
    else if (tick_i)             phase_q <= wrap ? '0 : phase_q + 1'b1;
  end

  assign bit_en_o = run_i && tick_i && wrap;

endmodule

// File: rtl/uclk_sync_master.sv
`timescale 1ns/1ps
module uclk_sync_master (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic run_i,
  input  logic tick_i,
  output logic xck_o,
  output logic rise_en_o,
  output logic fall_en_o
);
  logic xck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 xck_q <= 1'b0;
    else if (restart_i || !run_i) xck_q <= 1'b0;
    else if (tick_i)             xck_q <= ~xck_q;
  end

  assign xck_o     = xck_q;
  assign rise_en_o = run_i && tick_i && !xck_q;
  assign fall_en_o = run_i && tick_i && xck_q;

endmodule

// File: rtl/uclk_edge_sync.sv
`timescale 1ns/1ps
module uclk_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   lvl, prev_q;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[g] <= 1'b0;
        else         sync_q[g] <= pin_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[g] <= 1'b0;
        else         sync_q[g] <= sync_q[g-1];
      end
    end
  end

  assign lvl = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl;
  end

  assign rise_o = lvl && !prev_q;
  assign fall_o = !lvl && prev_q;

endmodule

// File: rtl/uclk_gen.sv
`timescale 1ns/1ps
module uclk_gen
  import uclk_pkg::*;
#(
  parameter int DIV_W       = 12,
  parameter int OVS_NORM    = 16,
  parameter int OVS_DBL     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_mode_i,
  input  logic             dbl_speed_i,
  input  logic             xck_dir_i,
  input  logic [DIV_W-1:0] baud_div_i,
  input  logic             xck_i,
  output logic             tx_en_o,
  output logic             rx_en_o,
  output logic             xck_o,
  output logic             xck_oe_o
);
  clk_mode_e mode;
  logic restart, tick;
  logic run_async, run_master;
  logic async_bit_en;
  logic m_xck, m_rise, m_fall;
  logic s_rise, s_fall;

  uclk_cfg_watch #(.DIV_W(DIV_W)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sync_i   (sync_mode_i),
    .dbl_i    (dbl_speed_i),
    .dir_i    (xck_dir_i),
    .div_i    (baud_div_i),
    .mode_o   (mode),
    .restart_o(restart)
  );

  uclk_base_cnt #(.DIV_W(DIV_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(restart),
    .div_i    (baud_div_i),
    .tick_o   (tick)
  );

  assign run_async  = (mode == MODE_ASYNC_X16) || (mode == MODE_ASYNC_X8);
  assign run_master = (mode == MODE_SYNC_MASTER);

  uclk_async_phase #(.OVS_NORM(OVS_NORM), .OVS_DBL(OVS_DBL)) u_phase (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(restart),
    .run_i    (run_async),
    .dbl_i    (mode == MODE_ASYNC_X8),
    .tick_i   (tick),
    .bit_en_o (async_bit_en)
  );

  uclk_sync_master u_mst (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(restart),
    .run_i    (run_master),
    .tick_i   (tick),
    .xck_o    (m_xck),
    .rise_en_o(m_rise),
    .fall_en_o(m_fall)
  );

  uclk_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_slv (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i (xck_i),
    .rise_o(s_rise),
    .fall_o(s_fall)
  );

  always_comb begin
    tx_en_o  = 1'b0;
    rx_en_o  = 1'b0;
    xck_o    = 1'b0;
    xck_oe_o = 1'b0;
    unique case (mode)
      MODE_ASYNC_X16, MODE_ASYNC_X8: begin
        rx_en_o = tick;
        tx_en_o = async_bit_en;
      end
      MODE_SYNC_MASTER: begin
        rx_en_o  = m_rise;
        tx_en_o  = m_fall;
        xck_o    = m_xck;
        xck_oe_o = 1'b1;
      end
      MODE_SYNC_SLAVE: begin
        rx_en_o = s_rise;
        tx_en_o = s_fall;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/uclk_gen_chk.sv
`timescale 1ns/1ps
module uclk_gen_chk #(
  parameter int DIV_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sync_mode_i,
  input logic             dbl_speed_i,
  input logic             xck_dir_i,
  input logic [DIV_W-1:0] baud_div_i,
  input logic             xck_i,
  input logic             tx_en_o,
  input logic             rx_en_o,
  input logic             xck_o,
  input logic             xck_oe_o
);
  logic is_master, is_slave;
  assign is_master = sync_mode_i && xck_dir_i;
  assign is_slave  = sync_mode_i && !xck_dir_i;

  AST_ASYNC_PIN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_mode_i |-> (!xck_oe_o && !xck_o)); // R6

  AST_ASYNC_TX_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sync_mode_i && tx_en_o) |-> rx_en_o); // R3

  AST_MASTER_DRIVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_master |-> xck_oe_o); // R7

  AST_MASTER_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_master && rx_en_o) |=> (xck_o || !(sync_mode_i && xck_dir_i))); // R7

  AST_MASTER_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_master && tx_en_o) |=> !xck_o); // R7

  AST_SYNC_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_mode_i |-> !(tx_en_o && rx_en_o)); // R7

  AST_SLAVE_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_slave |-> (!xck_oe_o && !xck_o)); // R8

  AST_SLAVE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_slave && rx_en_o) |=> !rx_en_o); // R8

endmodule

bind uclk_gen uclk_gen_chk #(.DIV_W(DIV_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sync_mode_i(sync_mode_i),
  .dbl_speed_i(dbl_speed_i),
  .xck_dir_i  (xck_dir_i),
  .baud_div_i (baud_div_i),
  .xck_i      (xck_i),
  .tx_en_o    (tx_en_o),
  .rx_en_o    (rx_en_o),
  .xck_o      (xck_o),
  .xck_oe_o   (xck_oe_o)
);

// File: tb/sim_uclk_gen.sv
`timescale 1ns/1ps
module sim_uclk_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sync_m = 1'b0, dbl = 1'b0, dir = 1'b0, xck_in = 1'b0;
  logic [11:0] div = '0;
  logic        tx_en, rx_en, xck_out, xck_oe;

  int checks = 0, fails = 0;
  bit done = 0;

  // observation results
  int n_tx, n_rx, tx1, tx2, rx1, rx2, oe_hi, oe_lo, xck_hi, xck_hi1, both;

  always #2.5 clk = ~clk;

  uclk_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .sync_mode_i(sync_m), .dbl_speed_i(dbl),
    .xck_dir_i(dir), .baud_div_i(div), .xck_i(xck_in),
    .tx_en_o(tx_en), .rx_en_o(rx_en), .xck_o(xck_out), .xck_oe_o(xck_oe)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // cycle i counts posedges since the call; sampling at the following negedge
  task automatic observe(input int ncyc, input int half, input int flip_at,
                         input logic [11:0] nd, input logic nb);
    n_tx = 0; n_rx = 0; tx1 = 0; tx2 = 0; rx1 = 0; rx2 = 0;
    oe_hi = 0; oe_lo = 0; xck_hi = 0; xck_hi1 = 0; both = 0;
    for (int i = 1; i <= ncyc; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (tx_en) begin n_tx++; if (tx1 == 0) tx1 = i; else if (tx2 == 0) tx2 = i; end
      if (rx_en) begin n_rx++; if (rx1 == 0) rx1 = i; else if (rx2 == 0) rx2 = i; end
      if (tx_en && rx_en) both++;
      if (xck_oe) oe_hi++; else oe_lo++;
      if (xck_out) begin xck_hi++; if (xck_hi1 == 0) xck_hi1 = i; end
      if (half > 0 && (i % half) == 0) xck_in = ~xck_in;
      if (i == flip_at) begin div = nd; dbl = nb; end
    end
  endtask

  task automatic t_reset;
    sync_m = 1'b0; dbl = 1'b0; dir = 1'b1; div = 12'd3;
    repeat (3) @(negedge clk);
    chk("R10 tx_en in reset", tx_en, 0);
    chk("R10 rx_en in reset", rx_en, 0);
    chk("R10 xck_o in reset", xck_out, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_async_x16;
    observe(140, 0, 0, 12'd0, 1'b0);
    chk("R2 first rx_en", rx1, 4);
    chk("R2 rx_en spacing", rx2 - rx1, 4);
    chk("R2 rx_en count", n_rx, 35);
    chk("R3 first tx_en full bit", tx1, 64);
    chk("R3 tx_en spacing", tx2 - tx1, 64);
    chk("R3 tx_en count", n_tx, 2);
    chk("R3 tx_en with rx_en", both, 2);
    chk("R1 R6 oe low async with dir=1", oe_hi, 0);
    chk("R6 xck_o low async", xck_hi, 0);
  endtask

  task automatic t_async_x8;
    dbl = 1'b1; div = 12'd2;
    observe(50, 0, 0, 12'd0, 1'b0);
    chk("R4 first rx_en", rx1, 3);
    chk("R4 first tx_en", tx1, 24);
    chk("R4 tx_en spacing", tx2 - tx1, 24);
    chk("R4 tx_en count", n_tx, 2);
  endtask

  task automatic t_async_restart;
    dbl = 1'b0; dir = 1'b0; div = 12'd3;
    observe(70, 0, 30, 12'd1, 1'b0);
    chk("R9 first tx_en after divisor change", tx1, 62);
    chk("R9 tx_en count", n_tx, 1);
    chk("R9 rx_en count across change", n_rx, 27);
  endtask

  task automatic t_async_pin_ignored;
    div = 12'd3;
    observe(140, 3, 0, 12'd0, 1'b0);
    chk("R6 tx_en with pin toggling", tx1, 64);
    chk("R6 tx_en spacing with pin toggling", tx2 - tx1, 64);
    chk("R6 rx_en count with pin toggling", n_rx, 35);
    chk("R6 oe low with pin toggling", oe_hi, 0);
  endtask

  task automatic t_master;
    sync_m = 1'b1; dir = 1'b1; dbl = 1'b0; div = 12'd4;
    observe(40, 0, 0, 12'd0, 1'b0);
    chk("R7 first rx_en", rx1, 5);
    chk("R7 first tx_en", tx1, 10);
    chk("R7 second rx_en", rx2, 15);
    chk("R7 second tx_en", tx2, 20);
    chk("R7 rx_en count", n_rx, 4);
    chk("R7 tx_en count", n_tx, 4);
    chk("R7 xck_o first high", xck_hi1, 6);
    chk("R7 xck_o high cycles", xck_hi, 20);
    chk("R1 R7 oe always high", oe_lo, 0);
    chk("R7 tx rx exclusive", both, 0);
  endtask

  task automatic t_master_dbl_ignored;
    div = 12'd3;
    observe(20, 0, 9, 12'd3, 1'b1);
    chk("R5 first rx_en", rx1, 4);
    chk("R5 first tx_en", tx1, 8);
    chk("R5 rx_en after dbl flip", rx2, 12);
    chk("R5 tx_en after dbl flip", tx2, 16);
  endtask

  task automatic t_slave;
    dir = 1'b0; dbl = 1'b0; div = 12'd5; xck_in = 1'b0;
    observe(40, 6, 0, 12'd5, 1'b0);
    chk("R8 first rx_en", rx1, 8);
    chk("R8 second rx_en", rx2, 20);
    chk("R8 first tx_en", tx1, 14);
    chk("R8 second tx_en", tx2, 26);
    chk("R8 rx_en count", n_rx, 3);
    chk("R8 tx_en count", n_tx, 3);
    chk("R8 oe low", oe_hi, 0);
    chk("R8 xck_o low", xck_hi, 0);
  endtask

  initial begin
    t_reset();
    t_async_x16();
    t_async_x8();
    t_async_restart();
    t_async_pin_ignored();
    t_master();
    t_master_dbl_ignored();
    t_slave();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #100us;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired (all requirements) actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule